// File: doc/BRIEF.md
# Multi-Port Set/Clear GPIO Controller

A memory-mapped pin controller serving four bidirectional banks, a group of input-only pins and a group of output-only pins. Software reaches it over a plain 32-bit register bus (byte address, write strobe, write data, read strobe, read data). Output levels and pin directions are never written directly: each has a write-one-to-set word and a write-one-to-clear word, so one bus write can change any subset of pins without a read-modify-write. Read-only state words return the synchronized pin inputs, the output latches and the direction latches.

Bank 3 has no register words of its own. Its output levels sit in the upper bits of the word shared with the output-only pins, its directions sit in the upper bits of bank 2's direction words, and its inputs are scattered through the word shared with the input-only pins. A 32-bit multiplexer-select latch is held with set/clear/state access but routes nothing.

Top module: `pinbank_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, every `*_out` and `*_oe` pin and `bus_rdata` are 0; reset also clears the multiplexer-select latch.
- R2: A 1 in a set word bit drives the matching latch to 1 and a 1 in a clear word bit drives it to 0, visible on the pins after the writing clock edge; 0 bits leave the latch unchanged.
- R3: Direction set bits make a pin an output (`oe` = 1); direction clear bits make it an input (`oe` = 0).
- R4: For banks 0 to 2, pin n is bit n of every word of its bank. Bank 0: input 0x40, output set/clear/state 0x44/0x48/0x4C, direction set/clear/state 0x50/0x54/0x58. Bank 1: the same layout at 0x60 to 0x78. Bank 2: direction set/clear/state 0x10/0x14/0x18, input 0x1C, output set/clear 0x20/0x24.
- R5: Bank 3 pin n uses bit n+25 in the shared output set/clear/state words 0x04/0x08/0x0C and bit n+25 in bank 2's direction words 0x10/0x14/0x18.
- R6: Output-only pin n is bit n of 0x04/0x08, and its level reads back at bit n of 0x0C.
- R7: Word 0x00 returns input-only pin i at bit i for bits 0 to 28, except that bits 10 to 14 return bank 3 pins 0 to 4 and bit 24 returns bank 3 pin 5; input-only positions 10 to 14 and 24 are ignored; bits 29 to 31 read 0.
- R8: Every pin input passes two flops: a change made before clock edge k is returned by a read sampled at edge k+2, and reads sampled at edges k and k+1 return the old value.
- R9: `bus_rdata` is registered: it loads the addressed word (state before any same-edge write) on an edge where `bus_rd` is high and 0 otherwise; set words, clear words and unmapped or misaligned addresses read 0.
- R10: The multiplexer-select latch has set/clear/state words 0x28/0x2C/0x30, keeps all 32 bits and never changes any pin.
- R11: Bits of a set or clear word that map to no pin are discarded and read back 0 in the state word (bank 1 direction reads at most 0x00FFFFFF, word 0x18 at most 0x7E001FFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bank0_in | input | 8 | Bank 0 pin inputs |
| bank0_out | output | 8 | Bank 0 output levels |
| bank0_oe | output | 8 | Bank 0 output enables |
| bank1_in | input | 24 | Bank 1 pin inputs |
| bank1_out | output | 24 | Bank 1 output levels |
| bank1_oe | output | 24 | Bank 1 output enables |
| bank2_in | input | 13 | Bank 2 pin inputs |
| bank2_out | output | 13 | Bank 2 output levels |
| bank2_oe | output | 13 | Bank 2 output enables |
| bank3_in | input | 6 | Bank 3 pin inputs |
| bank3_out | output | 6 | Bank 3 output levels |
| bank3_oe | output | 6 | Bank 3 output enables |
| gpin_in | input | 29 | Input-only pins, by bit position |
| gpout | output | 24 | Output-only pin levels |

## Verification
The bench aims at the shared words: a bank 3 direction or level write that landed on bank 2's low bits or on the output-only pins would show on the wrong pins, and a wrong scatter of bank 3 inputs in word 0x00 (or letting input-only positions 10 to 14 and 24 through) would give a visibly different read. It pushes all-ones into every set word so that a missing mask shows up as stray state bits, and holds a read open across a pin change so that a synchronizer one flop short or long moves the change by one cycle. It writes the multiplexer-select latch while watching every pin, and pulses reset mid-run after state has been built up.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    // storage words, one set/clear register each
    localparam int ST_P0_OUT = 0;
    localparam int ST_P0_DIR = 1;
    localparam int ST_P1_OUT = 2;
    localparam int ST_P1_DIR = 3;
    localparam int ST_P2_OUT = 4;
    localparam int ST_P2_DIR = 5;   // also carries bank 3 directions
    localparam int ST_P3_OUT = 6;   // output-only pins plus bank 3 levels
    localparam int ST_MUX    = 7;
    localparam int ST_N      = 8;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_P3_IN, SEL_P3_OSET, SEL_P3_OCLR, SEL_P3_OST,
        SEL_P2_DSET, SEL_P2_DCLR, SEL_P2_DST, SEL_P2_IN, SEL_P2_OSET, SEL_P2_OCLR,
        SEL_MX_SET, SEL_MX_CLR, SEL_MX_ST,
        SEL_P0_IN, SEL_P0_OSET, SEL_P0_OCLR, SEL_P0_OST, SEL_P0_DSET, SEL_P0_DCLR, SEL_P0_DST,
        SEL_P1_IN, SEL_P1_OSET, SEL_P1_OCLR, SEL_P1_OST, SEL_P1_DSET, SEL_P1_DCLR, SEL_P1_DST
    } rsel_e;

    function automatic rsel_e addr_decode(input logic [ADDR_W-1:0] a);
        case (a)
            8'h00: return SEL_P3_IN;
            8'h04: return SEL_P3_OSET;
            8'h08: return SEL_P3_OCLR;
            8'h0C: return SEL_P3_OST;
            8'h10: return SEL_P2_DSET;
            8'h14: return SEL_P2_DCLR;
            8'h18: return SEL_P2_DST;
            8'h1C: return SEL_P2_IN;
            8'h20: return SEL_P2_OSET;
            8'h24: return SEL_P2_OCLR;
            8'h28: return SEL_MX_SET;
            8'h2C: return SEL_MX_CLR;
            8'h30: return SEL_MX_ST;
            8'h40: return SEL_P0_IN;
            8'h44: return SEL_P0_OSET;
            8'h48: return SEL_P0_OCLR;
            8'h4C: return SEL_P0_OST;
            8'h50: return SEL_P0_DSET;
            8'h54: return SEL_P0_DCLR;
            8'h58: return SEL_P0_DST;
            8'h60: return SEL_P1_IN;
            8'h64: return SEL_P1_OSET;
            8'h68: return SEL_P1_OCLR;
            8'h6C: return SEL_P1_OST;
            8'h70: return SEL_P1_DSET;
            8'h74: return SEL_P1_DCLR;
            8'h78: return SEL_P1_DST;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic rsel_e set_code(input int idx);
        case (idx)
            ST_P0_OUT: return SEL_P0_OSET;
            ST_P0_DIR: return SEL_P0_DSET;
            ST_P1_OUT: return SEL_P1_OSET;
            ST_P1_DIR: return SEL_P1_DSET;
            ST_P2_OUT: return SEL_P2_OSET;
            ST_P2_DIR: return SEL_P2_DSET;
            ST_P3_OUT: return SEL_P3_OSET;
            default:   return SEL_MX_SET;
        endcase
    endfunction

    function automatic rsel_e clr_code(input int idx);
        case (idx)
            ST_P0_OUT: return SEL_P0_OCLR;
            ST_P0_DIR: return SEL_P0_DCLR;
            ST_P1_OUT: return SEL_P1_OCLR;
            ST_P1_DIR: return SEL_P1_DCLR;
            ST_P2_OUT: return SEL_P2_OCLR;
            ST_P2_DIR: return SEL_P2_DCLR;
            ST_P3_OUT: return SEL_P3_OCLR;
            default:   return SEL_MX_CLR;
        endcase
    endfunction

    // true for the write-only strobe words, which read back zero
    function automatic logic is_strobe(input rsel_e s);
        return (s == SEL_P3_OSET) || (s == SEL_P3_OCLR) || (s == SEL_P2_DSET) ||
               (s == SEL_P2_DCLR) || (s == SEL_P2_OSET) || (s == SEL_P2_OCLR) ||
               (s == SEL_MX_SET)  || (s == SEL_MX_CLR)  || (s == SEL_P0_OSET) ||
               (s == SEL_P0_OCLR) || (s == SEL_P0_DSET) || (s == SEL_P0_DCLR) ||
               (s == SEL_P1_OSET) || (s == SEL_P1_OCLR) || (s == SEL_P1_DSET) ||
               (s == SEL_P1_DCLR);
    endfunction

    function automatic logic [WORD_W-1:0] field_ones(input int lo, input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (b >= lo && b < lo + n) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    // cycles since reset, saturating; lets the latency check stay inside the window
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_SYNC_TWO_FLOPS: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (q == $past(d, 2))); // R8

endmodule

// File: rtl/pinbank_setclr.sv
module pinbank_setclr #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    always_comb begin
        set_v = set_en ? (wdata & MASK) : '0;
        clr_v = clr_en ? wdata : '0;
    end

    // clear applied after set: a bit hit by both ends at 0
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_v) & ~clr_v;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK))); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((q & $past(wdata)) == '0)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(q)); // R2

endmodule

// File: rtl/pinbank_rdmux.sv
module pinbank_rdmux
    import pinbank_pkg::*;
#(
    parameter int N = ST_N
) (
    input  rsel_e                   sel,
    input  logic [N-1:0][WORD_W-1:0] st,
    input  logic [WORD_W-1:0]       in_p0,
    input  logic [WORD_W-1:0]       in_p1,
    input  logic [WORD_W-1:0]       in_p2,
    input  logic [WORD_W-1:0]       in_p3,
    output logic [WORD_W-1:0]       data
);

    always_comb begin
        case (sel)
            SEL_P0_IN:  data = in_p0;
            SEL_P1_IN:  data = in_p1;
            SEL_P2_IN:  data = in_p2;
            SEL_P3_IN:  data = in_p3;
            SEL_P0_OST: data = st[ST_P0_OUT];
            SEL_P0_DST: data = st[ST_P0_DIR];
            SEL_P1_OST: data = st[ST_P1_OUT];
            SEL_P1_DST: data = st[ST_P1_DIR];
            SEL_P2_DST: data = st[ST_P2_DIR];
            SEL_P3_OST: data = st[ST_P3_OUT];
            SEL_MX_ST:  data = st[ST_MUX];
            default:    data = '0;
        endcase
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int P0_W       = 8,
    parameter int P1_W       = 24,
    parameter int P2_W       = 13,
    parameter int P3_W       = 6,
    parameter int GPI_W      = 29,
    parameter int GPO_W      = 24,
    parameter int P3_OUT_LSB = 25,
    parameter int P3_IN_LSB  = 10,
    parameter int P3_IN_LAST = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [P0_W-1:0]   bank0_in,
    output logic [P0_W-1:0]   bank0_out,
    output logic [P0_W-1:0]   bank0_oe,
    input  logic [P1_W-1:0]   bank1_in,
    output logic [P1_W-1:0]   bank1_out,
    output logic [P1_W-1:0]   bank1_oe,
    input  logic [P2_W-1:0]   bank2_in,
    output logic [P2_W-1:0]   bank2_out,
    output logic [P2_W-1:0]   bank2_oe,
    input  logic [P3_W-1:0]   bank3_in,
    output logic [P3_W-1:0]   bank3_out,
    output logic [P3_W-1:0]   bank3_oe,
    input  logic [GPI_W-1:0]  gpin_in,
    output logic [GPO_W-1:0]  gpout
);

    localparam int SYNC_W = P0_W + P1_W + P2_W + P3_W + GPI_W;
    localparam int OFS_B1 = P0_W;
    localparam int OFS_B2 = OFS_B1 + P1_W;
    localparam int OFS_B3 = OFS_B2 + P2_W;
    localparam int OFS_GI = OFS_B3 + P3_W;

    localparam logic [WORD_W-1:0] M_P0  = field_ones(0, P0_W);
    localparam logic [WORD_W-1:0] M_P1  = field_ones(0, P1_W);
    localparam logic [WORD_W-1:0] M_P2  = field_ones(0, P2_W);
    localparam logic [WORD_W-1:0] M_B3  = field_ones(P3_OUT_LSB, P3_W);
    localparam logic [WORD_W-1:0] M_P2D = M_P2 | M_B3;
    localparam logic [WORD_W-1:0] M_P3O = field_ones(0, GPO_W) | M_B3;
    localparam logic [WORD_W-1:0] M_ALL = '1;
    localparam logic [ST_N*WORD_W-1:0] ST_MASKS =
        {M_ALL, M_P3O, M_P2D, M_P2, M_P1, M_P1, M_P0, M_P0};

    rsel_e sel;
    assign sel = addr_decode(bus_addr);

    // ---------------- set/clear storage ----------------
    logic [ST_N-1:0]             wr_set;
    logic [ST_N-1:0]             wr_clr;
    logic [ST_N-1:0][WORD_W-1:0] st_q;

    always_comb begin
        for (int i = 0; i < ST_N; i++) begin
            wr_set[i] = bus_wr && (sel == set_code(i));
            wr_clr[i] = bus_wr && (sel == clr_code(i));
        end
    end

    for (genvar i = 0; i < ST_N; i++) begin : g_store
        pinbank_setclr #(
            .W    (WORD_W),
            .MASK (ST_MASKS[i*WORD_W +: WORD_W])
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .set_en (wr_set[i]),
            .clr_en (wr_clr[i]),
            .wdata  (bus_wdata),
            .q      (st_q[i])
        );
    end

    assign bank0_out = st_q[ST_P0_OUT][P0_W-1:0];
    assign bank0_oe  = st_q[ST_P0_DIR][P0_W-1:0];
    assign bank1_out = st_q[ST_P1_OUT][P1_W-1:0];
    assign bank1_oe  = st_q[ST_P1_DIR][P1_W-1:0];
    assign bank2_out = st_q[ST_P2_OUT][P2_W-1:0];
    assign bank2_oe  = st_q[ST_P2_DIR][P2_W-1:0];
    assign bank3_out = st_q[ST_P3_OUT][P3_OUT_LSB +: P3_W];
    assign bank3_oe  = st_q[ST_P2_DIR][P3_OUT_LSB +: P3_W];
    assign gpout     = st_q[ST_P3_OUT][GPO_W-1:0];

    // ---------------- input path ----------------
    logic [SYNC_W-1:0] pin_s;

    pinbank_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({gpin_in, bank3_in, bank2_in, bank1_in, bank0_in}),
        .q   (pin_s)
    );

    logic [WORD_W-1:0] in_p0, in_p1, in_p2, in_p3;

    always_comb begin
        in_p0 = '0;
        in_p1 = '0;
        in_p2 = '0;
        in_p3 = '0;
        in_p0[P0_W-1:0] = pin_s[0 +: P0_W];
        in_p1[P1_W-1:0] = pin_s[OFS_B1 +: P1_W];
        in_p2[P2_W-1:0] = pin_s[OFS_B2 +: P2_W];
        // input-only pins, leaving the positions that bank 3 occupies
        for (int i = 0; i < GPI_W; i++) begin
            if (!((i >= P3_IN_LSB && i < P3_IN_LSB + P3_W - 1) || i == P3_IN_LAST))
                in_p3[i] = pin_s[OFS_GI + i];
        end
        // bank 3 inputs: a contiguous run, then the last pin apart
        for (int n = 0; n < P3_W - 1; n++) begin
            in_p3[P3_IN_LSB + n] = pin_s[OFS_B3 + n];
        end
        in_p3[P3_IN_LAST] = pin_s[OFS_B3 + P3_W - 1];
    end

    // ---------------- read path ----------------
    logic [WORD_W-1:0] rd_word;

    pinbank_rdmux #(.N(ST_N)) u_rdmux (
        .sel   (sel),
        .st    (st_q),
        .in_p0 (in_p0),
        .in_p1 (in_p1),
        .in_p2 (in_p2),
        .in_p3 (in_p3),
        .data  (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
        else             bus_rdata <= '0;
    end

    // ---------------- assertions ----------------
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({bank0_out, bank0_oe, bank1_out, bank1_oe, bank2_out, bank2_oe,
                         bank3_out, bank3_oe, gpout, bus_rdata} == '0)); // R1

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0)); // R9

    AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && is_strobe(sel)) |=> (bus_rdata == '0)); // R9

    AST_B3_DIR_FROM_P2_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_P2_DSET) |=>
        ((bank3_oe & $past(bus_wdata[P3_OUT_LSB +: P3_W])) == $past(bus_wdata[P3_OUT_LSB +: P3_W]))); // R5

    AST_MUX_NO_PIN_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (sel == SEL_MX_SET || sel == SEL_MX_CLR)) |=>
        $stable({bank0_out, bank0_oe, bank1_out, bank1_oe, bank2_out, bank2_oe,
                 bank3_out, bank3_oe, gpout})); // R10

endmodule

// File: tb/sim_pinbank_ctrl.sv
`timescale 1ns/1ps
module sim_pinbank_ctrl;

    logic        clk;
    logic        rst;
    logic [7:0]  b_addr;
    logic        b_wr;
    logic [31:0] b_wdata;
    logic        b_rd;
    logic [31:0] b_rdata;
    logic [7:0]  p0_in, p0_out, p0_oe;
    logic [23:0] p1_in, p1_out, p1_oe;
    logic [12:0] p2_in, p2_out, p2_oe;
    logic [5:0]  p3_in, p3_out, p3_oe;
    logic [28:0] gi_in;
    logic [23:0] go_out;

    pinbank_ctrl u0 (
        .clk(clk), .rst(rst),
        .bus_addr(b_addr), .bus_wr(b_wr), .bus_wdata(b_wdata), .bus_rd(b_rd), .bus_rdata(b_rdata),
        .bank0_in(p0_in), .bank0_out(p0_out), .bank0_oe(p0_oe),
        .bank1_in(p1_in), .bank1_out(p1_out), .bank1_oe(p1_oe),
        .bank2_in(p2_in), .bank2_out(p2_out), .bank2_oe(p2_oe),
        .bank3_in(p3_in), .bank3_out(p3_out), .bank3_oe(p3_oe),
        .gpin_in(gi_in), .gpout(go_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_cmp  = 0;
    int n_bad  = 0;
    bit armed  = 0;
    bit done   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [7:0]  mo0, md0;
    logic [23:0] mo1, md1, mgo;
    logic [12:0] mo2, md2;
    logic [5:0]  mo3, md3;
    logic [31:0] mmx, exp_rd;
    logic [79:0] sa, sb;   // first and second synchronizer stage of every pin

    function automatic logic [31:0] mread(input logic [7:0] a);
        logic [31:0] w;
        logic [7:0]  s0;
        logic [23:0] s1;
        logic [12:0] s2;
        logic [5:0]  s3;
        logic [28:0] sg;
        {sg, s3, s2, s1, s0} = sb;
        w = 32'h0;
        case (a)
            8'h00: begin
                for (int i = 0; i < 29; i++)
                    if (!((i >= 10 && i <= 14) || i == 24)) w[i] = sg[i];
                w[14:10] = s3[4:0];
                w[24]    = s3[5];
            end
            8'h0C: w = {1'b0, mo3, 1'b0, mgo};
            8'h18: w = {1'b0, md3, 12'h000, md2};
            8'h1C: w = {19'h0, s2};
            8'h30: w = mmx;
            8'h40: w = {24'h0, s0};
            8'h4C: w = {24'h0, mo0};
            8'h58: w = {24'h0, md0};
            8'h60: w = {8'h0, s1};
            8'h6C: w = {8'h0, mo1};
            8'h78: w = {8'h0, md1};
            default: w = 32'h0;
        endcase
        return w;
    endfunction

    task automatic mwrite(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h04: begin mgo = mgo | d[23:0];  mo3 = mo3 | d[30:25];  end
            8'h08: begin mgo = mgo & ~d[23:0]; mo3 = mo3 & ~d[30:25]; end
            8'h10: begin md2 = md2 | d[12:0];  md3 = md3 | d[30:25];  end
            8'h14: begin md2 = md2 & ~d[12:0]; md3 = md3 & ~d[30:25]; end
            8'h20: mo2 = mo2 | d[12:0];
            8'h24: mo2 = mo2 & ~d[12:0];
            8'h28: mmx = mmx | d;
            8'h2C: mmx = mmx & ~d;
            8'h44: mo0 = mo0 | d[7:0];
            8'h48: mo0 = mo0 & ~d[7:0];
            8'h50: md0 = md0 | d[7:0];
            8'h54: md0 = md0 & ~d[7:0];
            8'h64: mo1 = mo1 | d[23:0];
            8'h68: mo1 = mo1 & ~d[23:0];
            8'h70: md1 = md1 | d[23:0];
            8'h74: md1 = md1 & ~d[23:0];
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mo0 = '0; md0 = '0; mo1 = '0; md1 = '0; mo2 = '0; md2 = '0;
            mo3 = '0; md3 = '0; mgo = '0; mmx = '0; exp_rd = '0; sa = '0; sb = '0;
        end else begin
            exp_rd = b_rd ? mread(b_addr) : 32'h0;
            if (b_wr) mwrite(b_addr, b_wdata);
            sb = sa;
            sa = {gi_in, p3_in, p2_in, p1_in, p0_in};
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            check("R2 bank0_out", {24'h0, p0_out}, {24'h0, mo0});
            check("R3 bank0_oe",  {24'h0, p0_oe},  {24'h0, md0});
            check("R2 bank1_out", {8'h0, p1_out},  {8'h0, mo1});
            check("R3 bank1_oe",  {8'h0, p1_oe},   {8'h0, md1});
            check("R2 bank2_out", {19'h0, p2_out}, {19'h0, mo2});
            check("R3 bank2_oe",  {19'h0, p2_oe},  {19'h0, md2});
            check("R5 bank3_out", {26'h0, p3_out}, {26'h0, mo3});
            check("R5 bank3_oe",  {26'h0, p3_oe},  {26'h0, md3});
            check("R6 gpout",     {8'h0, go_out},  {8'h0, mgo});
            check("R9 rdata",     b_rdata,         exp_rd);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_wr = 1'b0; b_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        b_rd = 1'b1; b_addr = a;
        @(negedge clk);
        v = b_rdata;
        b_rd = 1'b0;
    endtask

    // watchdog
    initial begin
        #(8 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    logic [31:0] v;

    initial begin
        rst = 1'b1; b_wr = 1'b0; b_rd = 1'b0; b_addr = 8'h0; b_wdata = 32'h0;
        p0_in = '0; p1_in = '0; p2_in = '0; p3_in = '0; gi_in = '0;
        repeat (3) @(posedge clk);
        armed = 1;
        @(negedge clk);
        check("R1 reset pins", {p0_out, p0_oe, p3_out, p3_oe}, 32'h0);
        check("R1 reset rdata", b_rdata, 32'h0);
        rst = 1'b0;

        // bank 0
        wr(8'h50, 32'h0000_00FF);
        check("R3 bank0 dir set", {24'h0, p0_oe}, 32'hFF);
        wr(8'h44, 32'h0000_00A5);
        check("R4 bank0 out set", {24'h0, p0_out}, 32'hA5);
        wr(8'h48, 32'h0000_000F);
        check("R2 bank0 out clr", {24'h0, p0_out}, 32'hA0);
        wr(8'h44, 32'h0);
        check("R2 zero set ignored", {24'h0, p0_out}, 32'hA0);
        wr(8'h48, 32'h0);
        check("R2 zero clr ignored", {24'h0, p0_out}, 32'hA0);
        wr(8'h54, 32'h0000_0081);
        check("R3 bank0 dir clr", {24'h0, p0_oe}, 32'h7E);
        rd(8'h4C, v); check("R4 bank0 out state", v, 32'hA0);
        rd(8'h58, v); check("R4 bank0 dir state", v, 32'h7E);

        // bank 1 with out-of-range bits
        wr(8'h70, 32'hFFFF_FFFF);
        rd(8'h78, v); check("R11 bank1 dir masked", v, 32'h00FF_FFFF);
        wr(8'h64, 32'h00C3_5A01);
        wr(8'h68, 32'h0000_0001);
        rd(8'h6C, v); check("R4 bank1 out state", v, 32'h00C3_5A00);

        // bank 2 directions share a word with bank 3
        wr(8'h10, 32'hFFFF_FFFF);
        check("R5 bank3 oe from bank2 word", {26'h0, p3_oe}, 32'h3F);
        rd(8'h18, v); check("R11 shared dir word", v, 32'h7E00_1FFF);
        wr(8'h14, 32'h0200_0001);
        check("R5 bank3 pin0 to input", {26'h0, p3_oe}, 32'h3E);
        check("R3 bank2 pin0 to input", {19'h0, p2_oe}, 32'h1FFE);
        wr(8'h20, 32'h0000_1555);
        check("R4 bank2 out", {19'h0, p2_out}, 32'h1555);

        // shared output word
        wr(8'h04, 32'hFFFF_FFFF);
        check("R6 gpout all set", {8'h0, go_out}, 32'h00FF_FFFF);
        check("R5 bank3 out all set", {26'h0, p3_out}, 32'h3F);
        wr(8'h08, 32'h4000_0001);
        check("R6 gpout pin0 clr", {8'h0, go_out}, 32'h00FF_FFFE);
        check("R5 bank3 pin5 clr", {26'h0, p3_out}, 32'h1F);
        rd(8'h0C, v); check("R5 shared out state", v, 32'h3EFF_FFFE);

        // select latch
        wr(8'h28, 32'hDEAD_BEEF);
        wr(8'h2C, 32'h0000_FFFF);
        rd(8'h30, v); check("R10 select latch", v, 32'hDEAD_0000);
        check("R10 pins untouched", {24'h0, p0_out}, 32'hA0);

        // strobe and unmapped reads
        rd(8'h04, v); check("R9 set word reads zero", v, 32'h0);
        rd(8'h74, v); check("R9 clr word reads zero", v, 32'h0);
        rd(8'h3C, v); check("R9 unmapped reads zero", v, 32'h0);
        rd(8'h41, v); check("R9 misaligned reads zero", v, 32'h0);

        // input word scatter
        @(negedge clk); gi_in = 29'h1FFF_FFFF; p3_in = 6'h00;
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R7 input-only holes", v, 32'h1EFF_83FF);
        @(negedge clk); gi_in = 29'h0; p3_in = 6'h3F;
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R7 bank3 scatter", v, 32'h0100_7C00);
        @(negedge clk); p3_in = 6'h20;
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R7 bank3 pin5 at bit24", v, 32'h0100_0000);
        @(negedge clk); p2_in = 13'h1ABC; p1_in = 24'hC3A5F0;
        repeat (3) @(negedge clk);
        rd(8'h1C, v); check("R4 bank2 input", v, 32'h0000_1ABC);
        rd(8'h60, v); check("R4 bank1 input", v, 32'h00C3_A5F0);

        // two-flop latency, read held open across the change
        @(negedge clk);
        p0_in = 8'h5A; b_rd = 1'b1; b_addr = 8'h40;
        @(negedge clk); check("R8 first edge old", b_rdata, 32'h0);
        @(negedge clk); check("R8 second edge old", b_rdata, 32'h0);
        @(negedge clk); check("R8 third edge new", b_rdata, 32'h5A);
        b_rd = 1'b0;

        // read sees state before a same-edge write
        @(negedge clk);
        b_rd = 1'b1; b_wr = 1'b1; b_addr = 8'h30; b_wdata = 32'h0;
        @(negedge clk); check("R9 read before write", b_rdata, 32'hDEAD_0000);
        b_rd = 1'b0; b_wr = 1'b0;

        // reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 reset clears pins", {p1_oe, p0_oe}, 32'h0);
        rst = 1'b0;
        rd(8'h30, v); check("R1 reset clears select latch", v, 32'h0);
        rd(8'h18, v); check("R1 reset clears directions", v, 32'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule